// File: doc/BRIEF.md
# Host-Target Mailbox

This block is a pair of 64-bit mailbox registers that a 32-bit processor bus reaches as four word locations. One register carries commands from the target to the host and the other carries responses from the host back to the target. The target writes a command word as two 32-bit halves. When the upper half lands, the block decodes the word into a device byte, a command byte and a 48-bit payload, then acts on it.

Console output commands push a byte out on a byte-stream output. Console input commands are held as a pending request until a byte arrives on the byte-stream input, and that byte is then returned through the response register. An exit command raises a sticky halt output along with an exit code. The target can also write the response register itself. Reads have no side effects.

Top module: `mbox_top`

## Requirements
- R1: After reset, all four word locations read zero and both `txValid` and `haltOut` are low.
- R2: Accesses are 32-bit and little-endian. The command register's low word is at byte offset `TO_OFF` (default 8) and its high word at `TO_OFF+4`. The response register's low word is at `FR_OFF` (default 0) and its high word at `FR_OFF+4`. Any other offset reads zero, and writes to it change nothing.
- R3: A write to the command low word loads bits 31:0 (with bits 63:32 zero) and arms the high-word write, but only if the command register is zero. Otherwise the write is ignored and the high-word write is disarmed.
- R4: A write to the command high word is ignored unless armed. When armed, it ORs the data into bits 63:32 and decodes the result as device = bits 63:56, command = bits 55:48 and payload = bits 47:0.
- R5: Device 1, command 1 is a put. One cycle after the high write, `txValid` pulses for one cycle with `txByte` = payload[7:0]. The response register becomes {word[63:48], 40'h1, payload[7:0]}, and the command register clears.
- R6: Device 1, command 0 is a get. It stores word[63:48] as a pending request and clears the command register. The response register does not change.
- R7: When `rxValid` is high in a cycle with no bus write and a request is pending, the response register becomes {pending[63:48], 40'h1, rxByte} and the request is consumed. In any other case the input byte is dropped with no visible effect.
- R8: Device 0, command 0 with payload bit 0 set is an exit. `haltOut` rises and stays high, and `exitCode` = payload[47:1]. The command register keeps the word and the response register is unchanged.
- R9: Every other decoded word, including device 0, command 0 with payload bit 0 clear, sets the response register to {word[63:48], 48'h0} and clears the command register.
- R10: A write to the response low word loads {32'h0, data}. A write to its high word ORs the data into bits 63:32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrite | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| rxByte | input | 8 | Incoming console byte |
| rxValid | input | 1 | `rxByte` is offered this cycle |
| txByte | output | 8 | Outgoing console byte |
| txValid | output | 1 | One-cycle pulse, `txByte` is new |
| haltOut | output | 1 | Sticky exit request |
| exitCode | output | 47 | Exit code of the latest exit command |

## Verification
A stale arm flag shows up one bus write later. A high-word write either issues a command it should not, or fails to issue one, and either way the read-back value or `txValid` goes wrong at once. A wrong pending state shows up the cycle after an input byte arrives, because the response register either changes when it should hold or holds when it should change. Since every cycle compares the read-back word and the output strobes against a behavioural model, a corrupted register is caught no later than the next read of its address.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W    = 32;
  localparam int MBOX_W    = 64;
  localparam int HEAD_W    = 16;
  localparam int PAYLOAD_W = MBOX_W - HEAD_W;
  localparam int EXIT_W    = PAYLOAD_W - 1;
  localparam int BYTE_W    = 8;

  localparam logic [7:0] DEV_SYS  = 8'd0;
  localparam logic [7:0] DEV_CONS = 8'd1;
  localparam logic [7:0] CMD_SYS  = 8'd0;
  localparam logic [7:0] CMD_GET  = 8'd0;
  localparam logic [7:0] CMD_PUT  = 8'd1;

  typedef struct packed {
    logic toLoadLo;
    logic toCommit;
    logic toClear;
    logic frLoadLo;
    logic frOrHi;
    logic frPutResp;
    logic frZeroResp;
    logic frRx;
    logic pendSave;
    logic pendClear;
    logic txFire;
    logic haltFire;
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TO_OFF = 8,
  parameter int FR_OFF = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrite,
  input  logic                rxValid,
  input  logic [HEAD_W-1:0]   cmdHead,
  input  logic                payloadLsb,
  input  logic                tohostZero,
  input  logic                pendValid,
  output mboxStrobes_t        strobes
);
  localparam logic [ADDR_W-1:0] A_TO_LO = ADDR_W'(TO_OFF);
  localparam logic [ADDR_W-1:0] A_TO_HI = ADDR_W'(TO_OFF + 4);
  localparam logic [ADDR_W-1:0] A_FR_LO = ADDR_W'(FR_OFF);
  localparam logic [ADDR_W-1:0] A_FR_HI = ADDR_W'(FR_OFF + 4);

  logic allowQ;
  logic [7:0] devField, cmdField;

  assign devField = cmdHead[15:8];
  assign cmdField = cmdHead[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) allowQ <= 1'b0;
    else if (busWrite && busAddr == A_TO_LO) allowQ <= tohostZero;
  end

  always_comb begin
    strobes = '0;
    if (busWrite) begin
      if (busAddr == A_TO_LO && tohostZero) strobes.toLoadLo = 1'b1;
      if (busAddr == A_TO_HI && allowQ) begin
        if (devField == DEV_SYS && cmdField == CMD_SYS && payloadLsb) begin
          strobes.toCommit = 1'b1;
          strobes.haltFire = 1'b1;
        end else if (devField == DEV_CONS && cmdField == CMD_GET) begin
          strobes.pendSave = 1'b1;
          strobes.toClear  = 1'b1;
        end else if (devField == DEV_CONS && cmdField == CMD_PUT) begin
          strobes.txFire    = 1'b1;
          strobes.frPutResp = 1'b1;
          strobes.toClear   = 1'b1;
        end else begin
          strobes.frZeroResp = 1'b1;
          strobes.toClear    = 1'b1;
        end
      end
      if (busAddr == A_FR_LO) strobes.frLoadLo = 1'b1;
      if (busAddr == A_FR_HI) strobes.frOrHi = 1'b1;
    end else if (rxValid && pendValid) begin
      strobes.frRx      = 1'b1;
      strobes.pendClear = 1'b1;
    end
  end
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TO_OFF = 8,
  parameter int FR_OFF = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWdata,
  output logic [WORD_W-1:0]   busRdata,
  input  logic [BYTE_W-1:0]   rxByte,
  input  mboxStrobes_t        strobes,
  output logic [HEAD_W-1:0]   cmdHead,
  output logic                payloadLsb,
  output logic                tohostZero,
  output logic                pendValid,
  output logic [MBOX_W-1:0]   tohostQ,
  output logic [MBOX_W-1:0]   fromhostQ,
  output logic [BYTE_W-1:0]   txByte,
  output logic                txValid,
  output logic                haltOut,
  output logic [EXIT_W-1:0]   exitCode
);
  localparam logic [ADDR_W-1:0] A_TO_LO = ADDR_W'(TO_OFF);
  localparam logic [ADDR_W-1:0] A_TO_HI = ADDR_W'(TO_OFF + 4);
  localparam logic [ADDR_W-1:0] A_FR_LO = ADDR_W'(FR_OFF);
  localparam logic [ADDR_W-1:0] A_FR_HI = ADDR_W'(FR_OFF + 4);
  localparam int PAD_W = PAYLOAD_W - BYTE_W - 1;

  logic [MBOX_W-1:0] cmdWord;
  logic [HEAD_W-1:0] pendHeadQ;

  assign cmdWord    = tohostQ | {busWdata, {WORD_W{1'b0}}};
  assign cmdHead    = cmdWord[MBOX_W-1 -: HEAD_W];
  assign payloadLsb = cmdWord[0];
  assign tohostZero = (tohostQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tohostQ   <= '0;
      fromhostQ <= '0;
      pendHeadQ <= '0;
      pendValid <= 1'b0;
      txByte    <= '0;
      txValid   <= 1'b0;
      haltOut   <= 1'b0;
      exitCode  <= '0;
    end else begin
      txValid <= strobes.txFire;
      if (strobes.txFire) txByte <= cmdWord[BYTE_W-1:0];

      if (strobes.toLoadLo)      tohostQ <= {{WORD_W{1'b0}}, busWdata};
      else if (strobes.toCommit) tohostQ <= cmdWord;
      else if (strobes.toClear)  tohostQ <= '0;

      if (strobes.frLoadLo)        fromhostQ <= {{WORD_W{1'b0}}, busWdata};
      else if (strobes.frOrHi)     fromhostQ <= fromhostQ | {busWdata, {WORD_W{1'b0}}};
      else if (strobes.frPutResp)  fromhostQ <= {cmdHead, {PAD_W{1'b0}}, 1'b1, cmdWord[BYTE_W-1:0]};
      else if (strobes.frZeroResp) fromhostQ <= {cmdHead, {PAYLOAD_W{1'b0}}};
      else if (strobes.frRx)       fromhostQ <= {pendHeadQ, {PAD_W{1'b0}}, 1'b1, rxByte};

      if (strobes.pendSave) begin
        pendHeadQ <= cmdHead;
        pendValid <= 1'b1;
      end else if (strobes.pendClear) begin
        pendHeadQ <= '0;
        pendValid <= 1'b0;
      end

      if (strobes.haltFire) begin
        haltOut  <= 1'b1;
        exitCode <= cmdWord[PAYLOAD_W-1:1];
      end
    end
  end

  always_comb begin
    unique case (busAddr)
      A_TO_LO: busRdata = tohostQ[WORD_W-1:0];
      A_TO_HI: busRdata = tohostQ[MBOX_W-1:WORD_W];
      A_FR_LO: busRdata = fromhostQ[WORD_W-1:0];
      A_FR_HI: busRdata = fromhostQ[MBOX_W-1:WORD_W];
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TO_OFF = 8,
  parameter int FR_OFF = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [7:0]        rxByte,
  input  logic              rxValid,
  output logic [7:0]        txByte,
  output logic              txValid,
  output logic              haltOut,
  output logic [46:0]       exitCode
);
  mboxStrobes_t      strobes;
  logic [HEAD_W-1:0] cmdHead;
  logic              payloadLsb, tohostZero, pendValid;
  logic [MBOX_W-1:0] tohostQ, fromhostQ;

  mbox_ctrl #(.ADDR_W(ADDR_W), .TO_OFF(TO_OFF), .FR_OFF(FR_OFF)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .rxValid(rxValid), .cmdHead(cmdHead), .payloadLsb(payloadLsb),
    .tohostZero(tohostZero), .pendValid(pendValid), .strobes(strobes)
  );

  mbox_dp #(.ADDR_W(ADDR_W), .TO_OFF(TO_OFF), .FR_OFF(FR_OFF)) uDp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .rxByte(rxByte), .strobes(strobes),
    .cmdHead(cmdHead), .payloadLsb(payloadLsb), .tohostZero(tohostZero),
    .pendValid(pendValid), .tohostQ(tohostQ), .fromhostQ(fromhostQ),
    .txByte(txByte), .txValid(txValid), .haltOut(haltOut), .exitCode(exitCode)
  );
endmodule

// File: rtl/mbox_checks.sv
module mbox_checks #(
  parameter int ADDR_W = 4,
  parameter int TO_OFF = 8,
  parameter int FR_OFF = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic              rxValid,
  input logic              txValid,
  input logic              haltOut,
  input logic              pendValid,
  input logic [63:0]       tohostQ,
  input logic [63:0]       fromhostQ
);
  localparam logic [ADDR_W-1:0] A_TO_LO = ADDR_W'(TO_OFF);
  localparam logic [ADDR_W-1:0] A_TO_HI = ADDR_W'(TO_OFF + 4);
  localparam logic [ADDR_W-1:0] A_FR_LO = ADDR_W'(FR_OFF);
  localparam logic [ADDR_W-1:0] A_FR_HI = ADDR_W'(FR_OFF + 4);

  logic otherAddr;
  assign otherAddr = busAddr != A_TO_LO && busAddr != A_TO_HI &&
                     busAddr != A_FR_LO && busAddr != A_FR_HI;

  AST_TX_AFTER_HIGH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(busWrite && busAddr == A_TO_HI)); // R5
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    haltOut |=> haltOut); // R8
  AST_EXIT_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltOut) |-> tohostQ[0]); // R8
  AST_LOW_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == A_TO_LO && tohostQ != 64'd0) |=> $stable(tohostQ)); // R3
  AST_RX_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrite && rxValid && !pendValid) |=> $stable(fromhostQ)); // R7
  AST_OTHER_ADDR_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && otherAddr) |=> ($stable(tohostQ) && $stable(fromhostQ))); // R2
endmodule

bind mbox_top mbox_checks #(.ADDR_W(ADDR_W), .TO_OFF(TO_OFF), .FR_OFF(FR_OFF)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
  .rxValid(rxValid), .txValid(txValid), .haltOut(haltOut),
  .pendValid(pendValid), .tohostQ(tohostQ), .fromhostQ(fromhostQ)
);

// File: tb/sim_mbox_top.sv
module sim_mbox_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;
  localparam int ADDR_W = 4;
  localparam int TO_OFF = 8;
  localparam int FR_OFF = 0;

  logic clk = 1'b0, rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0] rxByte = '0;
  logic rxValid = 1'b0;
  logic [7:0] txByte;
  logic txValid, haltOut;
  logic [46:0] exitCode;

  int vecCount = 0, missCount = 0;
  string curReq = "R1";

  mbox_top #(.ADDR_W(ADDR_W), .TO_OFF(TO_OFF), .FR_OFF(FR_OFF)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .rxByte(rxByte),
    .rxValid(rxValid), .txByte(txByte), .txValid(txValid),
    .haltOut(haltOut), .exitCode(exitCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [63:0] mTo, mFr, mWord;
  logic [15:0] mPend;
  logic mPendV, mAllow, mTxV, mHalt;
  logic [7:0] mTxB;
  logic [46:0] mExit;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTo = 0; mFr = 0; mPend = 0; mPendV = 0; mAllow = 0;
      mTxV = 0; mTxB = 0; mHalt = 0; mExit = 0;
    end else begin
      mTxV = 0;
      if (busWrite) begin
        if (int'(busAddr) == TO_OFF) begin
          if (mTo == 0) begin mTo = {32'd0, busWdata}; mAllow = 1; end
          else mAllow = 0;
        end else if (int'(busAddr) == TO_OFF + 4) begin
          if (mAllow) begin
            mWord = mTo | ({32'd0, busWdata} << 32);
            if (mWord[63:56] == 0 && mWord[55:48] == 0 && mWord[0]) begin
              mHalt = 1; mExit = mWord[47:1]; mTo = mWord;
            end else if (mWord[63:56] == 1 && mWord[55:48] == 0) begin
              mPend = mWord[63:48]; mPendV = 1; mTo = 0;
            end else if (mWord[63:56] == 1 && mWord[55:48] == 1) begin
              mTxV = 1; mTxB = mWord[7:0];
              mFr = {mWord[63:48], 48'h100 | 48'(mWord[7:0])}; mTo = 0;
            end else begin
              mFr = {mWord[63:48], 48'd0}; mTo = 0;
            end
          end
        end else if (int'(busAddr) == FR_OFF) begin
          mFr = {32'd0, busWdata};
        end else if (int'(busAddr) == FR_OFF + 4) begin
          mFr = mFr | ({32'd0, busWdata} << 32);
        end
      end else if (rxValid && mPendV) begin
        mFr = {mPend, 48'h100 | 48'(rxByte)}; mPendV = 0; mPend = 0;
      end
    end
  end

  function automatic logic [31:0] mRead(input int a);
    if (a == TO_OFF) return mTo[31:0];
    if (a == TO_OFF + 4) return mTo[63:32];
    if (a == FR_OFF) return mFr[31:0];
    if (a == FR_OFF + 4) return mFr[63:32];
    return 32'd0;
  endfunction

  task automatic cmp(input string what, input logic [63:0] got, input logic [63:0] exp);
    vecCount++;
    if (got !== exp) begin
      missCount++;
      $display("FAIL %s %s at %0t: got %h expected %h", curReq, what, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cmp("busRdata", 64'(busRdata), 64'(mRead(int'(busAddr))));
    cmp("txValid", 64'(txValid), 64'(mTxV));
    cmp("txByte", 64'(txByte), 64'(mTxB));
    cmp("haltOut", 64'(haltOut), 64'(mHalt));
    cmp("exitCode", 64'(exitCode), 64'(mExit));
  end

  task automatic step(); @(posedge clk); #Q; endtask
  task automatic wr(input int a, input logic [31:0] d);
    busWrite = 1; busAddr = ADDR_W'(a); busWdata = d; step(); busWrite = 0;
  endtask
  task automatic rd(input int a); busAddr = ADDR_W'(a); step(); endtask
  task automatic rx(input logic [7:0] b);
    rxValid = 1; rxByte = b; step(); rxValid = 0;
  endtask
  task automatic rdAll();
    rd(TO_OFF); rd(TO_OFF + 4); rd(FR_OFF); rd(FR_OFF + 4);
  endtask
  task automatic doReset();
    rstN = 0; step(); step(); rstN = 1; step();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    missCount++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    #Q;
    curReq = "R1"; doReset(); rdAll();
    curReq = "R2"; wr(2, 32'hffff_ffff); wr(13, 32'h1234_5678); rd(2); rd(13); rd(5); rdAll();
    curReq = "R5"; wr(TO_OFF, 32'h0000_0041); wr(TO_OFF + 4, 32'h0101_0000); rdAll();
    curReq = "R4"; wr(TO_OFF + 4, 32'h0101_00AA); rdAll();
    curReq = "R6"; wr(TO_OFF, 0); wr(TO_OFF + 4, 32'h0100_0000); rdAll();
    curReq = "R7"; rx(8'h5a); rdAll(); rx(8'h33); rdAll();
    wr(TO_OFF, 0); wr(TO_OFF + 4, 32'h0100_0000);
    busWrite = 1; busAddr = ADDR_W'(3); rxValid = 1; rxByte = 8'h77; step();
    busWrite = 0; rxValid = 0; rdAll(); rx(8'h81); rdAll();
    curReq = "R9"; wr(TO_OFF, 32'h0000_0102); wr(TO_OFF + 4, 32'h0207_0000); rdAll();
    wr(TO_OFF, 32'h0000_0004); wr(TO_OFF + 4, 32'h0000_0000); rdAll();
    curReq = "R10"; wr(FR_OFF, 32'hdead_beef); rdAll(); wr(FR_OFF + 4, 32'h1234_0000); rdAll();
    wr(FR_OFF + 4, 32'h0000_5678); rdAll();
    curReq = "R8"; wr(TO_OFF, 32'd11); wr(TO_OFF + 4, 32'd0); rdAll(); step(); step();
    curReq = "R3"; doReset();
    wr(TO_OFF, 32'd5); wr(TO_OFF, 32'd7); rdAll();
    wr(TO_OFF + 4, 32'h0101_0000); rdAll();
    step();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule